// File: doc/BRIEF.md
# Packet Receive FIFO with Overflow Recovery

This block buffers received packets, one byte per entry, between a line-side writer that cannot be stalled and a system-side reader. Each entry holds a data byte and two tags: end-of-packet and errored. The reader drains entries in arrival order through a valid/ready handshake, and sees the tags as sideband signals.

The writer has no backpressure, so a write can arrive when every slot is occupied. That is an overflow, and the block handles it in four ways:
- The packet being written is cut short. Its newest stored byte is tagged as both the end of the packet and errored.
- A sticky status bit is set. It drives an interrupt through an enable input.
- The block enters a recovery mode and drops every incoming byte.
- Recovery ends only at a start-of-packet byte that arrives when the free space has reached a programmable restart level. The level is a 4-bit value counted in units of DEPTH/16 entries.

This hysteresis keeps a slow reader from causing a string of back-to-back overflows. Outside recovery, the restart level has no effect.

Top module: `pkt_rx_fifo`

## Requirements
- R1: Entries leave in the order they were stored. `rd_valid` is high whenever at least one entry is held. An entry is removed on a cycle with `rd_valid` and `rd_ready` both high. While `rd_ready` is low, the presented entry stays unchanged.
- R2: In normal operation, each stored entry presents its byte on `rd_data`, presents `rd_last` equal to the `wr_eop` it was written with, and presents `rd_err` = 0.
- R3: A byte written (`wr_valid` = 1) outside recovery while DEPTH entries are held is an overflow. The byte is not stored, and the overflow status bit is set.
- R4: On an overflow inside a packet that already has stored bytes, the most recently stored entry is changed to `rd_last` = 1 and `rd_err` = 1.
- R5: On an overflow at the first byte of a packet (no byte of it stored yet), the stored entries keep their tags and the whole packet is dropped.
- R6: After an overflow, every byte is dropped until a byte with `wr_sop` = 1 arrives in a cycle where the FIFO is not full and free entries >= `restart_lvl` * DEPTH/16. That byte is stored, and normal operation resumes with it.
- R7: Outside recovery, a byte is stored whenever fewer than DEPTH entries are held, whatever the value of `restart_lvl`.
- R8: `irq` equals the overflow status ANDed with `irq_en`. A one-cycle `irq_ack` pulse clears the status. A new overflow in the same cycle wins over the clear.
- R9: After reset, the FIFO is empty, the status bit is clear, and the block is not in recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Line-side byte present this cycle |
| wr_sop | input | 1 | Byte is the first of a packet |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_data | input | DW | Line-side data byte |
| restart_lvl | input | 4 | Recovery restart level, in units of DEPTH/16 free entries |
| irq_en | input | 1 | Interrupt enable (mask) |
| irq_ack | input | 1 | Clears the overflow status |
| rd_valid | output | 1 | An entry is presented |
| rd_ready | input | 1 | Reader accepts the presented entry |
| rd_data | output | DW | Presented data byte |
| rd_last | output | 1 | Presented entry ends a packet |
| rd_err | output | 1 | Presented entry ends a truncated, errored packet |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench builds the block with DEPTH = 16, the smallest legal depth. One restart-level unit is then exactly one free entry, so the threshold boundary can be hit precisely: the bench offers a packet at three free entries against a level of four, and again at four. The FIFO fills in sixteen writes, which brings overflow in mid-packet and overflow on a start-of-packet byte within a short run. At that depth only the power-of-two pointer variant is built.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

   typedef struct packed {
      logic last;
      logic err;
   } ent_tag_t;

   typedef enum logic {
      MODE_RUN     = 1'b0,
      MODE_RECOVER = 1'b1
   } wr_mode_e;

endpackage

// File: rtl/pkt_rx_fifo_level.sv
module pkt_rx_fifo_level #(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wr_idx,
   output logic [AW-1:0] newest_idx,
   output logic [AW-1:0] rd_idx,
   output logic [CW-1:0] count,
   output logic [CW-1:0] free,
   output logic          full,
   output logic          empty
);

   logic [AW-1:0] wr_nxt, rd_nxt;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt     = wr_idx + AW'(1);
         assign rd_nxt     = rd_idx + AW'(1);
         assign newest_idx = wr_idx - AW'(1);
      end else begin : g_wrap
         assign wr_nxt     = (wr_idx == AW'(DEPTH - 1)) ? '0 : wr_idx + AW'(1);
         assign rd_nxt     = (rd_idx == AW'(DEPTH - 1)) ? '0 : rd_idx + AW'(1);
         assign newest_idx = (wr_idx == '0) ? AW'(DEPTH - 1) : wr_idx - AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else begin
         if (push) wr_idx <= wr_nxt;
         if (pop)  rd_idx <= rd_nxt;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign free  = CW'(DEPTH) - count;
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

endmodule

// File: rtl/pkt_rx_fifo_store.sv
module pkt_rx_fifo_store
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_last,
   input  logic          mark_en,
   input  logic [AW-1:0] mark_idx,
   input  logic [AW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   output ent_tag_t      rd_tag
);

   logic [DW-1:0] data_arr [DEPTH];
   ent_tag_t      tag_arr  [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic [DW-1:0] dat_r;
         ent_tag_t      tag_r;
         logic          sel_wr, sel_mark;

         assign sel_wr   = push    && (wr_idx   == AW'(i));
         assign sel_mark = mark_en && (mark_idx == AW'(i));

         always_ff @(posedge clk) begin
            if (sel_wr) dat_r <= wr_data;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_r <= '0;
            end else if (sel_wr) begin
               tag_r.last <= wr_last;
               tag_r.err  <= 1'b0;
            end else if (sel_mark) begin
               tag_r.last <= 1'b1;
               tag_r.err  <= 1'b1;
            end
         end

         assign data_arr[i] = dat_r;
         assign tag_arr[i]  = tag_r;
      end
   endgenerate

   assign rd_data = data_arr[rd_idx];
   assign rd_tag  = tag_arr[rd_idx];

endmodule

// File: rtl/pkt_rx_fifo_wrctl.sv
module pkt_rx_fifo_wrctl
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int UNIT = DEPTH / 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_sop,
   input  logic          wr_eop,
   input  logic [3:0]    restart_lvl,
   input  logic          full,
   input  logic [CW-1:0] free,
   output logic          push,
   output logic          mark_en,
   output logic          ovf_evt,
   output logic          in_recover
);

   wr_mode_e      mode_q, mode_d;
   logic          open_q, open_d;
   logic [CW-1:0] thr_entries;
   logic          resume_ok;

   assign thr_entries = CW'(restart_lvl) * CW'(UNIT);
   assign resume_ok   = (free >= thr_entries) && !full;

   always_comb begin
      mode_d  = mode_q;
      open_d  = open_q;
      push    = 1'b0;
      mark_en = 1'b0;
      ovf_evt = 1'b0;
      if (wr_valid) begin
         unique case (mode_q)
            MODE_RUN: begin
               if (!full) begin
                  push   = 1'b1;
                  open_d = !wr_eop;
               end else begin
                  ovf_evt = 1'b1;
                  mark_en = open_q;
                  open_d  = 1'b0;
                  mode_d  = MODE_RECOVER;
               end
            end
            MODE_RECOVER: begin
               if (wr_sop && resume_ok) begin
                  push   = 1'b1;
                  open_d = !wr_eop;
                  mode_d = MODE_RUN;
               end
            end
            default: mode_d = MODE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RUN;
         open_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         open_q <= open_d;
      end
   end

   assign in_recover = (mode_q == MODE_RECOVER);

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
   import pkt_rx_fifo_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic          wr_sop,
   input  logic          wr_eop,
   input  logic [DW-1:0] wr_data,
   input  logic [3:0]    restart_lvl,
   input  logic          irq_en,
   input  logic          irq_ack,
   output logic          rd_valid,
   input  logic          rd_ready,
   output logic [DW-1:0] rd_data,
   output logic          rd_last,
   output logic          rd_err,
   output logic          irq
);

   generate
      if (DEPTH < 16 || (DEPTH % 16) != 0) begin : g_bad_depth
         $error("pkt_rx_fifo: DEPTH must be a multiple of 16, at least 16");
      end
      if (DW < 1) begin : g_bad_width
         $error("pkt_rx_fifo: DW must be positive");
      end
   endgenerate

   logic          push, pop, mark_en, ovf_evt, in_recover;
   logic          full, empty;
   logic [AW-1:0] wr_idx, newest_idx, rd_idx;
   logic [CW-1:0] lvl_count, lvl_free;
   ent_tag_t      rd_tag;
   logic          ovf_status;

   assign rd_valid = !empty;
   assign pop      = rd_valid && rd_ready;

   pkt_rx_fifo_level #(.DEPTH(DEPTH)) i_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .pop        (pop),
      .wr_idx     (wr_idx),
      .newest_idx (newest_idx),
      .rd_idx     (rd_idx),
      .count      (lvl_count),
      .free       (lvl_free),
      .full       (full),
      .empty      (empty)
   );

   pkt_rx_fifo_wrctl #(.DEPTH(DEPTH)) i_wrctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_sop      (wr_sop),
      .wr_eop      (wr_eop),
      .restart_lvl (restart_lvl),
      .full        (full),
      .free        (lvl_free),
      .push        (push),
      .mark_en     (mark_en),
      .ovf_evt     (ovf_evt),
      .in_recover  (in_recover)
   );

   pkt_rx_fifo_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .wr_last  (wr_eop),
      .mark_en  (mark_en),
      .mark_idx (newest_idx),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .rd_tag   (rd_tag)
   );

   assign rd_last = rd_tag.last;
   assign rd_err  = rd_tag.err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_status <= 1'b0;
      else if (ovf_evt)  ovf_status <= 1'b1;
      else if (irq_ack)  ovf_status <= 1'b0;
   end

   assign irq = ovf_status && irq_en;

endmodule

// File: rtl/pkt_rx_fifo_chk.sv
module pkt_rx_fifo_chk #(
   parameter int DEPTH = 32,
   parameter int DW    = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_sop,
   input logic          irq_en,
   input logic          irq,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [DW-1:0] rd_data,
   input logic [CW-1:0] lvl_count,
   input logic          in_recover,
   input logic          ovf_status
);

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_count <= CW'(DEPTH));

   p_ovf_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_count == CW'(DEPTH) && wr_valid && !in_recover) |=> ovf_status);

   p_recover_no_grow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_recover && !wr_sop) |=> (lvl_count <= $past(lvl_count)));

   p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind pkt_rx_fifo pkt_rx_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_valid   (wr_valid),
   .wr_sop     (wr_sop),
   .irq_en     (irq_en),
   .irq        (irq),
   .rd_valid   (rd_valid),
   .rd_ready   (rd_ready),
   .rd_data    (rd_data),
   .lvl_count  (lvl_count),
   .in_recover (in_recover),
   .ovf_status (ovf_status)
);

// File: tb/test_pkt_rx_fifo.sv
`timescale 1ns/1ps
module test_pkt_rx_fifo;

   localparam int DEPTH = 16;
   localparam int DW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid, wr_sop, wr_eop;
   logic [DW-1:0] wr_data;
   logic [3:0]    restart_lvl;
   logic          irq_en, irq_ack;
   logic          rd_valid, rd_ready;
   logic [DW-1:0] rd_data;
   logic          rd_last, rd_err, irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pkt_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) i_pkt_rx_fifo (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sop(wr_sop),
      .wr_eop(wr_eop), .wr_data(wr_data), .restart_lvl(restart_lvl),
      .irq_en(irq_en), .irq_ack(irq_ack), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
      .rd_err(rd_err), .irq(irq)
   );

   // vector: {sop, eop, data[7:0], expected last, expected err}
   localparam logic [11:0] VEC [8] = '{
      {1'b1, 1'b1, 8'h11, 1'b1, 1'b0},
      {1'b1, 1'b0, 8'h21, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h22, 1'b0, 1'b0},
      {1'b0, 1'b1, 8'h23, 1'b1, 1'b0},
      {1'b1, 1'b0, 8'h31, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h32, 1'b0, 1'b0},
      {1'b0, 1'b0, 8'h33, 1'b0, 1'b0},
      {1'b0, 1'b1, 8'h34, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push_byte(input logic sop, input logic eop, input logic [7:0] d);
      wr_valid = 1'b1; wr_sop = sop; wr_eop = eop; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
   endtask

   task automatic pop_chk(input string req, input logic [7:0] d, input logic l, input logic e);
      chk({req, " valid"}, 32'(rd_valid), 32'd1);
      chk({req, " data"},  32'(rd_data),  32'(d));
      chk({req, " last"},  32'(rd_last),  32'(l));
      chk({req, " err"},   32'(rd_err),   32'(e));
      rd_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_ready = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_data = '0;
      restart_lvl = 4'd0; irq_en = 1'b1; irq_ack = 1'b0; rd_ready = 1'b0;
      do_reset();

      // R9: empty and quiet after reset
      chk("R9 rd_valid", 32'(rd_valid), 32'd0);
      chk("R9 irq", 32'(irq), 32'd0);

      // R1 / R2: table walk, write all then drain in order
      foreach (VEC[i]) push_byte(VEC[i][11], VEC[i][10], VEC[i][9:2]);
      foreach (VEC[i]) pop_chk("R1 R2 table", VEC[i][9:2], VEC[i][1], VEC[i][0]);
      chk("R1 drained", 32'(rd_valid), 32'd0);
      chk("R3 no overflow yet", 32'(irq), 32'd0);

      // R3 / R4 / R6: mid-packet overflow, recovery at level 4
      restart_lvl = 4'd4;
      for (int i = 0; i < 20; i++) push_byte(i == 0, i == 19, 8'(i));
      chk("R3 irq after overflow", 32'(irq), 32'd1);
      irq_en = 1'b0;
      #1;
      chk("R8 masked", 32'(irq), 32'd0);
      irq_en = 1'b1;
      push_byte(1'b1, 1'b1, 8'h55);               // full: dropped
      for (int i = 0; i < 3; i++) pop_chk("R4 body", 8'(i), 1'b0, 1'b0);
      push_byte(1'b1, 1'b0, 8'h60);               // free 3 < 4: dropped
      push_byte(1'b0, 1'b1, 8'h61);
      pop_chk("R4 body", 8'd3, 1'b0, 1'b0);
      push_byte(1'b1, 1'b0, 8'h70);               // free 4: resumes
      push_byte(1'b0, 1'b1, 8'h71);
      for (int i = 4; i < 15; i++) pop_chk("R4 body", 8'(i), 1'b0, 1'b0);
      pop_chk("R4 truncated tail", 8'd15, 1'b1, 1'b1);
      pop_chk("R6 resumed first", 8'h70, 1'b0, 1'b0);
      pop_chk("R6 resumed last", 8'h71, 1'b1, 1'b0);
      chk("R6 dropped bytes absent", 32'(rd_valid), 32'd0);

      // R8: clear by acknowledge
      chk("R8 status held", 32'(irq), 32'd1);
      irq_ack = 1'b1;
      @(posedge clk); @(negedge clk);
      irq_ack = 1'b0;
      chk("R8 cleared", 32'(irq), 32'd0);

      // R7 / R5: high restart level ignored in normal mode; overflow at a packet start
      do_reset();
      restart_lvl = 4'd15;
      for (int i = 0; i < 16; i++) push_byte(i == 0, i == 15, 8'h80 + 8'(i));
      chk("R7 no overflow when filling", 32'(irq), 32'd0);
      push_byte(1'b1, 1'b0, 8'hEE);
      push_byte(1'b0, 1'b1, 8'hEF);
      chk("R5 overflow flagged", 32'(irq), 32'd1);
      for (int i = 0; i < 15; i++) pop_chk("R7 stored", 8'h80 + 8'(i), 1'b0, 1'b0);
      pop_chk("R5 prior packet untouched", 8'h8F, 1'b1, 1'b0);
      chk("R5 packet dropped", 32'(rd_valid), 32'd0);

      finish_run();
   end

endmodule